// File: doc/BRIEF.md
# Variable-Length Instruction Field Parser

This block receives the bytes of one machine instruction at a time over a valid/ready handshake and splits them into fields. The fields are an opcode of one or two bytes, an optional mode byte, an optional scale/index/base byte, an optional displacement and an optional immediate. They always arrive in that order, and the immediate is always the last field. How many bytes each field takes is not worked out here. A lookup stage upstream supplies it on side-band inputs that come with the first opcode byte.

Once the final byte is in, the block holds every decoded field steady and raises `done` for one cycle, together with the total byte count. The mode byte is reported as its three sub-fields, and so is the scale/index/base byte. The displacement and the immediate are assembled least significant byte first. A one-byte immediate can be sign-extended to the operand width. A synchronous reset or an `abort` pulse throws away a partly parsed instruction.

Top module: `insn_field_parser`

## Requirements
- R1: After `rst` or an `abort` pulse, `done` is 0, `in_ready` is 1 and `length` is 0. The next accepted byte starts a new instruction, and any partly received bytes are discarded.
- R2: The side-band inputs are sampled only when the first opcode byte is accepted, and later changes within the same instruction have no effect. `opcode` is `{8'h00, byte0}` for a one-byte opcode and `{byte0, byte1}` for a two-byte opcode (`sb_two_byte_op`=1).
- R3: When `sb_has_modrm`=1, the byte right after the opcode is split into `mod_f`=bits 7:6, `reg_f`=bits 5:3 and `rm_f`=bits 2:0.
- R4: When both `sb_has_modrm` and `sb_has_sib` are 1, the next byte is split into `scale_f`=bits 7:6, `index_f`=bits 5:3 and `base_f`=bits 2:0. `sb_has_sib` is ignored when there is no mode byte.
- R5: The displacement follows the mode/SIB bytes, or the opcode if those are absent. Its size code `sb_disp_code` is 0 for absent, 1 for one byte, 2 for two bytes and 3 for four bytes. It is assembled little-endian into `disp`, with the unused upper bits 0.
- R6: The immediate follows the displacement and uses the same size code on `sb_imm_code`. It is assembled little-endian into `imm`, with the upper bits 0 when no extension applies.
- R7: When `sb_sext`=1, `sb_wide`=1 and the immediate is one byte, bit 7 of the immediate fills `imm` up to bit 31 if `sb_opsize32`=1, and up to bit 15 otherwise. In every other case no extension is applied.
- R8: `reg_f` is always the raw bits 5:3 of the mode byte. `reg_is_ext` reports the `sb_reg_is_ext` value sampled for the instruction.
- R9: `done` is 1 for exactly one cycle, starting in the cycle after the last byte is accepted. While `done` is 1, `length` equals the total byte count (1 to 12) and `in_ready` is 0. Afterwards the block accepts a new instruction.
- R10: The fields of the mode byte, the SIB byte, the displacement and the immediate read 0 when that field is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abort | input | 1 | Drop the current instruction |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Byte can be taken |
| sb_two_byte_op | input | 1 | Opcode is two bytes |
| sb_has_modrm | input | 1 | Mode byte present |
| sb_has_sib | input | 1 | Scale/index/base byte present |
| sb_disp_code | input | 2 | Displacement size code |
| sb_imm_code | input | 2 | Immediate size code |
| sb_sext | input | 1 | Sign-extend request for a byte immediate |
| sb_wide | input | 1 | Operand is full width (not 8 bits) |
| sb_opsize32 | input | 1 | Full width is 32 bits (else 16) |
| sb_reg_is_ext | input | 1 | Reg field is an opcode extension |
| done | output | 1 | Instruction complete, one cycle |
| length | output | 4 | Total instruction bytes |
| opcode | output | 16 | Opcode bytes |
| mod_f | output | 2 | Mode byte bits 7:6 |
| reg_f | output | 3 | Mode byte bits 5:3 |
| rm_f | output | 3 | Mode byte bits 2:0 |
| reg_is_ext | output | 1 | Reg field usage flag |
| scale_f | output | 2 | SIB bits 7:6 |
| index_f | output | 3 | SIB bits 5:3 |
| base_f | output | 3 | SIB bits 2:0 |
| disp | output | 32 | Assembled displacement |
| imm | output | 32 | Assembled, possibly extended immediate |

## Verification
Every decoded field, `length` and `done` becomes valid one register stage after the rising edge that accepts the final byte. The bench drives bytes on the falling edge and checks every result on the falling edge right after that acceptance edge. One falling edge later it confirms that `done` has dropped. The reset and abort results are due one edge after the pulse, and they are sampled on the falling edge that follows.

// File: rtl/insn_field_parser.sv
module insn_field_parser (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  input  logic        sb_two_byte_op,
  input  logic        sb_has_modrm,
  input  logic        sb_has_sib,
  input  logic [1:0]  sb_disp_code,
  input  logic [1:0]  sb_imm_code,
  input  logic        sb_sext,
  input  logic        sb_wide,
  input  logic        sb_opsize32,
  input  logic        sb_reg_is_ext,
  output logic        done,
  output logic [3:0]  length,
  output logic [15:0] opcode,
  output logic [1:0]  mod_f,
  output logic [2:0]  reg_f,
  output logic [2:0]  rm_f,
  output logic        reg_is_ext,
  output logic [1:0]  scale_f,
  output logic [2:0]  index_f,
  output logic [2:0]  base_f,
  output logic [31:0] disp,
  output logic [31:0] imm
);

  typedef enum logic [2:0] {S_OPC, S_MODRM, S_SIB, S_DISP, S_IMM, S_DONE} state_t;

  state_t      st, nxt;
  logic [1:0]  idx;
  logic [3:0]  len;
  logic        q_two, q_modrm, q_sib, q_sext, q_wide, q_op32, q_ext;
  logic [1:0]  q_disp, q_imm;
  logic [15:0] op_r;
  logic [7:0]  modrm_r, sib_r;
  logic [31:0] disp_r, imm_r;

  function automatic logic [1:0] last_idx(input logic [1:0] code);
    case (code)
      2'd2:    return 2'd1;
      2'd3:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] nbytes(input logic [1:0] code);
    case (code)
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      2'd3:    return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  wire acc   = in_valid && in_ready;
  wire first = (st == S_OPC) && (idx == 2'd0);

  wire       e_two   = first ? sb_two_byte_op : q_two;
  wire       e_modrm = first ? sb_has_modrm   : q_modrm;
  wire       e_sib   = first ? sb_has_sib     : q_sib;
  wire [1:0] e_disp  = first ? sb_disp_code   : q_disp;
  wire [1:0] e_imm   = first ? sb_imm_code    : q_imm;

  wire [2:0] after_disp  = (e_imm  != 2'd0) ? S_IMM  : S_DONE;
  wire [2:0] after_sib   = (e_disp != 2'd0) ? S_DISP : after_disp;
  wire [2:0] after_modrm = e_sib   ? S_SIB   : after_sib;
  wire [2:0] after_opc   = e_modrm ? S_MODRM : after_sib;

  logic field_last;
  always_comb begin
    field_last = 1'b1;
    nxt = S_DONE;
    case (st)
      S_OPC:   begin field_last = (idx == {1'b0, e_two}); nxt = state_t'(after_opc); end
      S_MODRM: nxt = state_t'(after_modrm);
      S_SIB:   nxt = state_t'(after_sib);
      S_DISP:  begin field_last = (idx == last_idx(q_disp)); nxt = state_t'(after_disp); end
      S_IMM:   begin field_last = (idx == last_idx(q_imm)); nxt = S_DONE; end
      default: nxt = S_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st <= S_OPC;  idx <= 2'd0;  len <= 4'd0;
      q_two <= 1'b0; q_modrm <= 1'b0; q_sib <= 1'b0; q_disp <= 2'd0; q_imm <= 2'd0;
      q_sext <= 1'b0; q_wide <= 1'b0; q_op32 <= 1'b0; q_ext <= 1'b0;
      op_r <= 16'h0; modrm_r <= 8'h0; sib_r <= 8'h0; disp_r <= 32'h0; imm_r <= 32'h0;
    end else if (acc) begin
      if (first) begin
        q_two <= sb_two_byte_op; q_modrm <= sb_has_modrm;
        q_sib <= sb_has_modrm && sb_has_sib;
        q_disp <= sb_disp_code; q_imm <= sb_imm_code;
        q_sext <= sb_sext; q_wide <= sb_wide; q_op32 <= sb_opsize32; q_ext <= sb_reg_is_ext;
        modrm_r <= 8'h0; sib_r <= 8'h0; disp_r <= 32'h0; imm_r <= 32'h0;
        len <= 4'd1;
      end else begin
        len <= len + 4'd1;
      end
      case (st)
        S_OPC:   op_r <= first ? {8'h00, in_byte} : {op_r[7:0], in_byte};
        S_MODRM: modrm_r <= in_byte;
        S_SIB:   sib_r <= in_byte;
        S_DISP:  disp_r[8*idx +: 8] <= in_byte;
        S_IMM:   imm_r[8*idx +: 8] <= in_byte;
        default: ;
      endcase
      if (field_last) begin
        st  <= nxt;
        idx <= 2'd0;
      end else begin
        idx <= idx + 2'd1;
      end
    end else if (st == S_DONE) begin
      st <= S_OPC;
    end
  end

  wire ext8 = q_sext && q_wide && (q_imm == 2'd1);

  assign in_ready   = (st != S_DONE);
  assign done       = (st == S_DONE);
  assign length     = len;
  assign opcode     = op_r;
  assign mod_f      = modrm_r[7:6];
  assign reg_f      = modrm_r[5:3];
  assign rm_f       = modrm_r[2:0];
  assign reg_is_ext = q_ext;
  assign scale_f    = sib_r[7:6];
  assign index_f    = sib_r[5:3];
  assign base_f     = sib_r[2:0];
  assign disp       = disp_r;
  assign imm        = !ext8 ? imm_r :
                      q_op32 ? {{24{imm_r[7]}}, imm_r[7:0]} : {16'h0, {8{imm_r[7]}}, imm_r[7:0]};

  wire [3:0] want_len = (q_two ? 4'd2 : 4'd1) + {3'b0, q_modrm} + {3'b0, q_sib}
                        + nbytes(q_disp) + nbytes(q_imm);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (rst) done |-> length == want_len); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst) done |-> (length >= 4'd1 && length <= 4'd12)); // R9
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (rst) abort |=> (!done && length == 4'd0)); // R1
  AST_IMM_NO_EXT: assert property (@(posedge clk) disable iff (rst) (done && q_imm == 2'd1 && !q_sext) |-> imm[31:8] == 24'h0); // R7
  AST_SIB_ABSENT: assert property (@(posedge clk) disable iff (rst) (done && !q_sib) |-> {scale_f, index_f, base_f} == 8'h0); // R10

endmodule

// File: tb/tb_insn_field_parser.sv
module tb_insn_field_parser;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, abort, in_valid, in_ready;
  logic [7:0]  in_byte;
  logic        sb_two_byte_op, sb_has_modrm, sb_has_sib, sb_sext, sb_wide, sb_opsize32, sb_reg_is_ext;
  logic [1:0]  sb_disp_code, sb_imm_code;
  logic        done, reg_is_ext;
  logic [3:0]  length;
  logic [15:0] opcode;
  logic [1:0]  mod_f, scale_f;
  logic [2:0]  reg_f, rm_f, index_f, base_f;
  logic [31:0] disp, imm;

  insn_field_parser dut (
    .clk(clk), .rst(rst), .abort(abort), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .sb_two_byte_op(sb_two_byte_op), .sb_has_modrm(sb_has_modrm), .sb_has_sib(sb_has_sib),
    .sb_disp_code(sb_disp_code), .sb_imm_code(sb_imm_code), .sb_sext(sb_sext), .sb_wide(sb_wide),
    .sb_opsize32(sb_opsize32), .sb_reg_is_ext(sb_reg_is_ext),
    .done(done), .length(length), .opcode(opcode), .mod_f(mod_f), .reg_f(reg_f), .rm_f(rm_f),
    .reg_is_ext(reg_is_ext), .scale_f(scale_f), .index_f(index_f), .base_f(base_f),
    .disp(disp), .imm(imm)
  );

  typedef struct packed {
    logic        two, hm, hs;
    logic [1:0]  dc, ic;
    logic        s, w, op32, ext;
    logic [3:0]  n;
    logic [31:0] xdisp, xdimm;
    logic [95:0] bytes;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,4'd1, 32'h0,        32'h0,        96'h90},
    '{1'b0,1'b1,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,4'd2, 32'h0,        32'h0,        96'hD8_01},
    '{1'b0,1'b1,1'b1,2'd3,2'd3,1'b0,1'b1,1'b1,1'b1,4'd11,32'h12345678, 32'hDEADBEEF, 96'hDE_AD_BE_EF_12_34_56_78_8D_84_81},
    '{1'b1,1'b1,1'b0,2'd1,2'd0,1'b0,1'b1,1'b1,1'b0,4'd4, 32'h000000F0, 32'h0,        96'hF0_45_AF_0F},
    '{1'b0,1'b1,1'b0,2'd0,2'd1,1'b1,1'b1,1'b1,1'b1,4'd3, 32'h0,        32'hFFFFFF80, 96'h80_C1_83},
    '{1'b0,1'b1,1'b0,2'd0,2'd1,1'b1,1'b1,1'b0,1'b1,4'd3, 32'h0,        32'h0000FF80, 96'h80_C1_83},
    '{1'b0,1'b1,1'b0,2'd0,2'd1,1'b1,1'b0,1'b1,1'b1,4'd3, 32'h0,        32'h00000080, 96'h80_C1_83},
    '{1'b0,1'b1,1'b0,2'd0,2'd2,1'b1,1'b1,1'b1,1'b1,4'd4, 32'h0,        32'h00009234, 96'h92_34_C1_81},
    '{1'b1,1'b1,1'b1,2'd3,2'd3,1'b0,1'b1,1'b1,1'b0,4'd12,32'h04030201, 32'h08070605, 96'h08_07_06_05_04_03_02_01_24_04_3A_0F},
    '{1'b0,1'b1,1'b0,2'd0,2'd1,1'b1,1'b1,1'b1,1'b1,4'd3, 32'h0,        32'h0000007F, 96'h7F_C1_83},
    '{1'b0,1'b1,1'b0,2'd2,2'd0,1'b0,1'b1,1'b1,1'b0,4'd4, 32'h00001234, 32'h0,        96'h12_34_86_8B}
  };

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_sb(input vec_t v);
    sb_two_byte_op = v.two; sb_has_modrm = v.hm; sb_has_sib = v.hs;
    sb_disp_code = v.dc; sb_imm_code = v.ic; sb_sext = v.s; sb_wide = v.w;
    sb_opsize32 = v.op32; sb_reg_is_ext = v.ext;
  endtask

  task automatic run_vec(input vec_t v, input bit perturb, input string tag);
    int p;
    logic [7:0] b [12];
    logic [15:0] xop;
    logic [7:0] xm, xs;
    for (int i = 0; i < 12; i++) b[i] = v.bytes[8*i +: 8];
    set_sb(v);
    for (int i = 0; i < int'(v.n); i++) begin
      send_byte(b[i]);
      if (perturb && i == 0) begin
        sb_imm_code = 2'd0; sb_has_modrm = 1'b0; sb_sext = 1'b0; sb_two_byte_op = ~v.two;
      end
      if (i + 1 < int'(v.n)) chk({tag, " R9 done early"}, {31'b0, done}, 32'd0);
    end
    xop = v.two ? {b[0], b[1]} : {8'h00, b[0]};
    p = v.two ? 2 : 1;
    xm = v.hm ? b[p] : 8'h0;
    if (v.hm) p++;
    xs = (v.hm && v.hs) ? b[p] : 8'h0;
    chk({tag, " R9 done"},      {31'b0, done},     32'd1);
    chk({tag, " R9 in_ready"},  {31'b0, in_ready}, 32'd0);
    chk({tag, " R9 length"},    {28'b0, length},   {28'b0, v.n});
    chk({tag, " R2 opcode"},    {16'b0, opcode},   {16'b0, xop});
    chk({tag, " R3 modrm"},     {24'b0, mod_f, reg_f, rm_f}, {24'b0, xm});
    chk({tag, " R8 reg_is_ext"},{31'b0, reg_is_ext}, {31'b0, v.ext});
    chk({tag, " R4 sib"},       {24'b0, scale_f, index_f, base_f}, {24'b0, xs});
    chk({tag, " R5 disp"},      disp, v.xdisp);
    chk({tag, " R6 R7 imm"},    imm,  v.xdimm);
    @(negedge clk);
    chk({tag, " R9 done drop"}, {31'b0, done},     32'd0);
    chk({tag, " R9 ready back"},{31'b0, in_ready}, 32'd1);
  endtask

  initial begin
    vec_t v;
    rst = 1'b1; abort = 1'b0; in_valid = 1'b0; in_byte = 8'h0;
    set_sb(VECS[0]);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset done",     {31'b0, done},     32'd0);
    chk("R1 reset in_ready", {31'b0, in_ready}, 32'd1);
    chk("R1 reset length",   {28'b0, length},   32'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0, $sformatf("vec%0d", k));

    run_vec(VECS[4], 1'b1, "R2 sideband change ignored");

    v = VECS[2];
    set_sb(v);
    for (int i = 0; i < 3; i++) send_byte(v.bytes[8*i +: 8]);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R1 abort done",   {31'b0, done},   32'd0);
    chk("R1 abort length", {28'b0, length}, 32'd0);
    run_vec(VECS[1], 1'b0, "R1 after abort");

    set_sb(v);
    for (int i = 0; i < 5; i++) send_byte(v.bytes[8*i +: 8]);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 midreset length", {28'b0, length}, 32'd0);
    run_vec(VECS[3], 1'b0, "R1 after reset");

    v = '{1'b0,1'b0,1'b1,2'd1,2'd0,1'b0,1'b1,1'b1,1'b0,4'd2, 32'h000000A5, 32'h0, 96'hA5_A1};
    run_vec(v, 1'b0, "R4 R10 sib ignored without modrm");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule